// File: doc/BRIEF.md
# Windowed Vertical Sync Divider

This block counts half-line clock enables (two per line) and restarts its count, the divider reset, when a qualified vertical sync pulse arrives. An up/down confidence counter decides which reset window is active. A wide search window accepts almost any field length. A narrow window accepts only lengths close to the broadcast norm. The locked standard mode resets at exactly the norm length, whether or not a pulse arrives.

Each vsync start is taken from the level of `vsync_i` sampled on half-line ticks. The reset then happens one half-line tick later. When sync is missing, the divider still resets: at the upper limit of the wide window, at the end of the narrow window, or at the norm length when locked. With no transmitter present, the wide mode falls back to a fixed length so that the picture stays at a stable height. The measured field length, in half-line clocks, is held from one reset to the next.

Top module: `vsync_divider`

## Requirements
- R1: On reset, `hl_cnt_o`, `mode_o`, `ratio_o`, `div_rst_o` and `norm_lock_o` are all 0. On each tick of `hl_en_i` that does not reset the divider, `hl_cnt_o` rises by 1. Between ticks, count and mode hold.
- R2: A sync event is the first tick that samples `vsync_i` high after a low sample; the divider acts on it at the next tick. `div_rst_o` pulses for one clock after the deciding tick. At that point `hl_cnt_o` is 0 and `ratio_o` holds the field length, which is the count before the reset plus 1.
- R3: In wide mode (`mode_o`=0), a sync event resets the divider when the field length is between 488 and 576; events outside that range are ignored. With no accepted event, the divider resets at length 576 and confidence falls by 1, not below 0.
- R4: In narrow mode (`mode_o`=1) and norm-probe mode (`mode_o`=2), an event resets the divider only at lengths 522 to 528. Without one, the divider resets at 528 and confidence falls by 1. A fall below 1 returns the block to wide mode with confidence 0.
- R5: Wide-mode acceptances raise confidence. The 12th acceptance leaves wide mode. If that field was 525 long, the block goes to mode 2 with confidence 0; otherwise it goes to mode 1 with confidence 12. An accepted 525 field in mode 1 moves the block to mode 2 with confidence 0.
- R6: In mode 2, each accepted 525 field raises confidence. The 14th moves the block to standard mode (`mode_o`=3, `norm_lock_o`=1), with confidence 14.
- R7: In standard mode the divider resets at length 525 in every field. A sync event on that tick raises confidence, saturating at 14. Its absence lowers confidence, and a drop to 10 returns the block to wide mode.
- R8: In wide mode with `tx_present_i` low, the divider resets at length 528 when no event has been accepted.
- R9: With `tx_present_i` low, a sync event while `hl_cnt_o` is below 34 forces wide mode with confidence 0 from any mode.
- R10: While `force_wide_i` is high, wide-mode reset rules apply, `mode_o` reads 0 and confidence stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hl_en_i | input | 1 | Half-line tick enable |
| vsync_i | input | 1 | Separated vertical sync level |
| tx_present_i | input | 1 | Transmitter identified |
| force_wide_i | input | 1 | Force wide search window |
| hl_cnt_o | output | 10 | Half-line count since the last divider reset |
| div_rst_o | output | 1 | One-clock divider reset strobe |
| mode_o | output | 2 | 0 wide, 1 narrow, 2 norm probe, 3 standard |
| ratio_o | output | 10 | Last measured field length in half-line clocks |
| norm_lock_o | output | 1 | Standard-norm mode active |

## Verification
Acceptance of a sync pulse and the window's timeout reset can fall on the same tick. This happens when the event arrives exactly at the last length the window allows: 576 in wide mode, 528 in narrow mode, or 525 in standard mode. The bench provokes it by running the sync generator with periods of 576 and 525, and with a 530 period whose late pulses follow the narrow timeout. The behavioural model treats every such tick as an acceptance and not as a miss. The mode and the field lengths that follow show whether the design raised or lowered its confidence in those fields.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
  typedef enum logic [1:0] {
    MODE_WIDE   = 2'd0,
    MODE_NARROW = 2'd1,
    MODE_PROBE  = 2'd2,
    MODE_LOCK   = 2'd3
  } vdiv_mode_e;
endpackage

// File: rtl/vdiv_sync_edge.sv
module vdiv_sync_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hl_en_i,
  input  logic vsync_i,
  output logic ev_o
);
  logic vs_q, ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vs_q <= 1'b0;
      ev_q <= 1'b0;
    end else if (hl_en_i) begin
      vs_q <= vsync_i;
      ev_q <= vsync_i & ~vs_q;
    end
  end

  // event is consumed on the tick after detection: half a line late
  assign ev_o = ev_q;
endmodule

// File: rtl/vdiv_halfline_cnt.sv
module vdiv_halfline_cnt #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hl_en_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic             strobe_o
);
  logic [CNT_W-1:0] cnt_q, ratio_q;
  logic             strobe_q;

  assign nxt_o = cnt_q + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      ratio_q  <= '0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= hl_en_i & clr_i;
      if (hl_en_i) begin
        if (clr_i) begin
          cnt_q   <= '0;
          ratio_q <= nxt_o;
        end else begin
          cnt_q <= nxt_o;
        end
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign ratio_o  = ratio_q;
  assign strobe_o = strobe_q;
endmodule

// File: rtl/vdiv_lock_fsm.sv
module vdiv_lock_fsm
  import vdiv_pkg::*;
#(
  parameter int CNT_W        = 10,
  parameter int WIDE_LO      = 488,
  parameter int WIDE_HI      = 576,
  parameter int NAR_LO       = 522,
  parameter int NAR_HI       = 528,
  parameter int NORM         = 525,
  parameter int FALLBACK     = 528,
  parameter int BLANK_END    = 34,
  parameter int WIDE_APPROVE = 12,
  parameter int PROBE_TARGET = 14,
  parameter int LOCK_EXIT    = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hl_en_i,
  input  logic             ev_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic             tx_present_i,
  input  logic             force_wide_i,
  output logic             do_rst_o,
  output vdiv_mode_e       mode_o
);
  localparam int CONF_MAX = (WIDE_APPROVE > PROBE_TARGET) ? WIDE_APPROVE : PROBE_TARGET;
  localparam int CONF_W   = $clog2(CONF_MAX + 1);

  localparam logic [CNT_W-1:0] L_WLO = CNT_W'(WIDE_LO);
  localparam logic [CNT_W-1:0] L_WHI = CNT_W'(WIDE_HI);
  localparam logic [CNT_W-1:0] L_NLO = CNT_W'(NAR_LO);
  localparam logic [CNT_W-1:0] L_NHI = CNT_W'(NAR_HI);
  localparam logic [CNT_W-1:0] L_NRM = CNT_W'(NORM);
  localparam logic [CNT_W-1:0] L_FBK = CNT_W'(FALLBACK);
  localparam logic [CNT_W-1:0] L_BLK = CNT_W'(BLANK_END);

  localparam logic [CONF_W-1:0] C_ONE   = CONF_W'(1);
  localparam logic [CONF_W-1:0] C_APPR  = CONF_W'(WIDE_APPROVE);
  localparam logic [CONF_W-1:0] C_APPR1 = CONF_W'(WIDE_APPROVE - 1);
  localparam logic [CONF_W-1:0] C_PRB   = CONF_W'(PROBE_TARGET);
  localparam logic [CONF_W-1:0] C_PRB1  = CONF_W'(PROBE_TARGET - 1);
  localparam logic [CONF_W-1:0] C_EXIT1 = CONF_W'(LOCK_EXIT + 1);

  vdiv_mode_e        mode_q, mode_d, eff_mode;
  logic [CONF_W-1:0] conf_q, conf_d;
  logic              rst_c, in_wide, in_nar, is_norm;

  assign in_wide = ev_i && (nxt_i >= L_WLO) && (nxt_i <= L_WHI);
  assign in_nar  = ev_i && (nxt_i >= L_NLO) && (nxt_i <= L_NHI);
  assign is_norm = (nxt_i == L_NRM);

  always_comb begin
    eff_mode = force_wide_i ? MODE_WIDE : mode_q;
    mode_d   = eff_mode;
    conf_d   = conf_q;
    rst_c    = 1'b0;
    unique case (eff_mode)
      MODE_WIDE: begin
        if (in_wide) begin
          rst_c = 1'b1;
          if (conf_q >= C_APPR1) begin
            mode_d = is_norm ? MODE_PROBE : MODE_NARROW;
            conf_d = is_norm ? '0 : C_APPR;
          end else begin
            conf_d = conf_q + C_ONE;
          end
        end else if (nxt_i >= L_WHI || (!tx_present_i && nxt_i >= L_FBK)) begin
          rst_c = 1'b1;
          if (conf_q != '0) conf_d = conf_q - C_ONE;
        end
      end
      MODE_NARROW, MODE_PROBE: begin
        if (in_nar) begin
          rst_c = 1'b1;
          if (is_norm) begin
            if (eff_mode == MODE_NARROW) begin
              mode_d = MODE_PROBE;
              conf_d = '0;
            end else if (conf_q >= C_PRB1) begin
              mode_d = MODE_LOCK;
              conf_d = C_PRB;
            end else begin
              conf_d = conf_q + C_ONE;
            end
          end
        end else if (nxt_i >= L_NHI) begin
          rst_c = 1'b1;
          if (conf_q <= C_ONE) begin
            mode_d = MODE_WIDE;
            conf_d = '0;
          end else begin
            conf_d = conf_q - C_ONE;
          end
        end
      end
      default: begin
        if (nxt_i >= L_NRM) begin
          rst_c = 1'b1;
          if (ev_i) begin
            if (conf_q < C_PRB) conf_d = conf_q + C_ONE;
          end else if (conf_q <= C_EXIT1) begin
            mode_d = MODE_WIDE;
            conf_d = '0;
          end else begin
            conf_d = conf_q - C_ONE;
          end
        end
      end
    endcase
    // pulse in the blanking interval with no carrier: fall back to search
    if (force_wide_i || (!tx_present_i && ev_i && cnt_i < L_BLK)) begin
      mode_d = MODE_WIDE;
      conf_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_WIDE;
      conf_q <= '0;
    end else if (hl_en_i) begin
      mode_q <= mode_d;
      conf_q <= conf_d;
    end
  end

  assign do_rst_o = rst_c;
  assign mode_o   = mode_q;
endmodule

// File: rtl/vsync_divider.sv
module vsync_divider
  import vdiv_pkg::*;
#(
  parameter int WIDE_LO      = 488,
  parameter int WIDE_HI      = 576,
  parameter int NAR_LO       = 522,
  parameter int NAR_HI       = 528,
  parameter int NORM         = 525,
  parameter int FALLBACK     = 528,
  parameter int BLANK_END    = 34,
  parameter int WIDE_APPROVE = 12,
  parameter int PROBE_TARGET = 14,
  parameter int LOCK_EXIT    = 10,
  localparam int CNT_W       = $clog2(WIDE_HI + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hl_en_i,
  input  logic             vsync_i,
  input  logic             tx_present_i,
  input  logic             force_wide_i,
  output logic [CNT_W-1:0] hl_cnt_o,
  output logic             div_rst_o,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] ratio_o,
  output logic             norm_lock_o
);
  logic             ev, do_rst;
  logic [CNT_W-1:0] cnt, nxt;
  vdiv_mode_e       mode;

  vdiv_sync_edge i_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hl_en_i (hl_en_i),
    .vsync_i (vsync_i),
    .ev_o    (ev)
  );

  vdiv_halfline_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hl_en_i  (hl_en_i),
    .clr_i    (do_rst),
    .cnt_o    (cnt),
    .nxt_o    (nxt),
    .ratio_o  (ratio_o),
    .strobe_o (div_rst_o)
  );

  vdiv_lock_fsm #(
    .CNT_W(CNT_W), .WIDE_LO(WIDE_LO), .WIDE_HI(WIDE_HI), .NAR_LO(NAR_LO),
    .NAR_HI(NAR_HI), .NORM(NORM), .FALLBACK(FALLBACK), .BLANK_END(BLANK_END),
    .WIDE_APPROVE(WIDE_APPROVE), .PROBE_TARGET(PROBE_TARGET), .LOCK_EXIT(LOCK_EXIT)
  ) i_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .hl_en_i      (hl_en_i),
    .ev_i         (ev),
    .cnt_i        (cnt),
    .nxt_i        (nxt),
    .tx_present_i (tx_present_i),
    .force_wide_i (force_wide_i),
    .do_rst_o     (do_rst),
    .mode_o       (mode)
  );

  assign hl_cnt_o    = cnt;
  assign mode_o      = mode;
  assign norm_lock_o = (mode == MODE_LOCK);
endmodule

// File: rtl/vsync_divider_chk.sv
module vsync_divider_chk #(
  parameter int CNT_W   = 10,
  parameter int WIDE_LO = 488,
  parameter int WIDE_HI = 576,
  parameter int NAR_LO  = 522,
  parameter int NAR_HI  = 528,
  parameter int NORM    = 525
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hl_en_i,
  input logic             force_wide_i,
  input logic [CNT_W-1:0] hl_cnt_o,
  input logic             div_rst_o,
  input logic [1:0]       mode_o,
  input logic [CNT_W-1:0] ratio_o,
  input logic             norm_lock_o
);
  logic armed;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed <= 1'b0;
    else         armed <= 1'b1;
  end

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && $past(hl_en_i) && !div_rst_o |-> hl_cnt_o == $past(hl_cnt_o) + CNT_W'(1));

  assert_hold_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && !$past(hl_en_i) |-> $stable(hl_cnt_o) && $stable(mode_o));

  assert_strobe_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && div_rst_o |-> hl_cnt_o == '0 && $past(hl_en_i));

  assert_ratio_wide_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_rst_o |-> ratio_o >= CNT_W'(WIDE_LO) && ratio_o <= CNT_W'(WIDE_HI));

  assert_ratio_narrow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && div_rst_o && ($past(mode_o) == 2'd1 || $past(mode_o) == 2'd2) && !$past(force_wide_i)
    |-> ratio_o >= CNT_W'(NAR_LO) && ratio_o <= CNT_W'(NAR_HI));

  assert_ratio_lock_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed && div_rst_o && $past(norm_lock_o) && !$past(force_wide_i) |-> ratio_o == CNT_W'(NORM));
endmodule

bind vsync_divider vsync_divider_chk #(
  .CNT_W(CNT_W), .WIDE_LO(WIDE_LO), .WIDE_HI(WIDE_HI),
  .NAR_LO(NAR_LO), .NAR_HI(NAR_HI), .NORM(NORM)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hl_en_i(hl_en_i), .force_wide_i(force_wide_i),
  .hl_cnt_o(hl_cnt_o), .div_rst_o(div_rst_o), .mode_o(mode_o),
  .ratio_o(ratio_o), .norm_lock_o(norm_lock_o)
);

// File: tb/test_vsync_divider.sv
`timescale 1ns/1ps
module test_vsync_divider;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hl_en = 1'b0, vsync = 1'b0, tx = 1'b1, force_w = 1'b0;
  logic [9:0] cnt_o, ratio_o;
  logic [1:0] mode_o;
  logic div_rst, lock_o;

  int total = 0, bad = 0, cycles = 0;
  int gen_period = 525, ph = 0, div3 = 0;
  bit gen_on = 0, man = 0, seen_nar_miss = 0;

  // reference model state
  int m_cnt, m_mode, m_conf, m_ratio, m_rst, m_vsq, m_pend;

  vsync_divider i_vsync_divider (
    .clk_i(clk), .rst_ni(rst_n), .hl_en_i(hl_en), .vsync_i(vsync),
    .tx_present_i(tx), .force_wide_i(force_w), .hl_cnt_o(cnt_o),
    .div_rst_o(div_rst), .mode_o(mode_o), .ratio_o(ratio_o), .norm_lock_o(lock_o)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // stimulus: 2 of every 3 clocks carry a half-line tick; periodic sync generator
  always @(negedge clk) begin
    div3 = (div3 == 2) ? 0 : div3 + 1;
    hl_en = (div3 != 0);
    if (hl_en) ph = (ph + 1 >= gen_period) ? 0 : ph + 1;
    vsync = (gen_on && ph < 4) || man;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_mode = 0; m_conf = 0; m_ratio = 0; m_rst = 0; m_vsq = 0; m_pend = 0;
    end else begin
      m_rst = 0;
      if (hl_en) begin
        int n, em, nm, nc, rs;
        bit ev, win_w, win_n;
        n = m_cnt + 1; ev = (m_pend != 0);
        em = force_w ? 0 : m_mode; nm = em; nc = m_conf; rs = 0;
        win_w = ev && n >= 488 && n <= 576;
        win_n = ev && n >= 522 && n <= 528;
        if (em == 0) begin
          if (win_w) begin
            rs = 1;
            if (m_conf + 1 >= 12) begin nm = (n == 525) ? 2 : 1; nc = (n == 525) ? 0 : 12; end
            else nc = m_conf + 1;
          end else if (n >= 576 || (!tx && n >= 528)) begin
            rs = 1; nc = (m_conf > 0) ? m_conf - 1 : 0;
          end
        end else if (em == 3) begin
          if (n >= 525) begin
            rs = 1;
            if (ev) nc = (m_conf < 14) ? m_conf + 1 : 14;
            else if (m_conf - 1 <= 10) begin nm = 0; nc = 0; end
            else nc = m_conf - 1;
          end
        end else begin
          if (win_n) begin
            rs = 1;
            if (n == 525) begin
              if (em == 1) begin nm = 2; nc = 0; end
              else if (m_conf + 1 >= 14) begin nm = 3; nc = 14; end
              else nc = m_conf + 1;
            end
          end else if (n >= 528) begin
            rs = 1;
            if (m_conf - 1 < 1) begin nm = 0; nc = 0; end else nc = m_conf - 1;
          end
        end
        if (force_w || (!tx && ev && m_cnt < 34)) begin nm = 0; nc = 0; end
        if (rs != 0) begin m_cnt = 0; m_ratio = n; m_rst = 1; end else m_cnt = n;
        m_mode = nm; m_conf = nc;
        m_pend = (vsync && !m_vsq) ? 1 : 0;
        m_vsq = vsync;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R1 count", cnt_o, m_cnt);
      chk("R2 strobe", div_rst, m_rst);
      chk("R2 ratio", ratio_o, m_ratio);
      chk("R5 mode", mode_o, m_mode);
      chk("R6 lock flag", lock_o, (m_mode == 3) ? 1 : 0);
      if (div_rst && mode_o == 2'd1 && ratio_o == 10'd528) seen_nar_miss = 1;
    end
    if (cycles > 195000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected<=195000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!hl_en) @(posedge clk);
    end
    #1;
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1;
    chk("R1 reset count", cnt_o, 0);
    chk("R1 reset mode", mode_o, 0);
    chk("R1 reset ratio", ratio_o, 0);
    chk("R1 reset lock", lock_o, 0);
    rst_n = 1'b1;
    gen_on = 1;
    ticks(8 * 525);
    chk("R5 still wide before 12 acceptances", mode_o, 0);
    ticks(37 * 525);
    chk("R6 standard mode reached", mode_o, 3);
    chk("R6 lock flag", lock_o, 1);
    chk("R7 ratio 525 locked", ratio_o, 525);
    gen_on = 0;
    ticks(2 * 525);
    chk("R7 still locked after two misses", mode_o, 3);
    chk("R7 resets at 525 without sync", ratio_o, 525);
    ticks(6 * 525);
    chk("R7 returns to wide after misses", mode_o, 0);
    ticks(2 * 576);
    chk("R3 timeout at 576", ratio_o, 576);
    tx = 0;
    ticks(3 * 576);
    chk("R8 fallback 528 no carrier", ratio_o, 528);
    tx = 1; gen_period = 576; gen_on = 1;
    ticks(4 * 576);
    gen_period = 530;
    ticks(30 * 530);
    chk("R4 narrow miss reset at 528 observed", seen_nar_miss, 1);
    gen_period = 525; force_w = 1;
    ticks(8 * 525);
    chk("R10 forced wide", mode_o, 0);
    force_w = 0;
    ticks(40 * 525);
    chk("R6 relock after release", mode_o, 3);
    gen_on = 0; tx = 0;
    wait (div_rst === 1'b1);
    ticks(10);
    man = 1;
    ticks(6);
    man = 0;
    ticks(3);
    chk("R9 blanking pulse without carrier forces wide", mode_o, 0);
    ticks(20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule